// File: doc/BRIEF.md
# PCI Target Back-End Address Decoder

This block is the user-side logic behind a PCI target core. At the start of every target transaction the core shows the target address on a shared 32-bit address/data bus and the bus command on the 4-bit command/byte-enable lines, marked by a one-cycle address-valid strobe. The block decodes that command into read and write indications and matches the address against two base registers: one for a 4 KB memory window and one for a 256-byte I/O window. A window only matches while its space is enabled in a small command register. The block captures the address in the same cycle.

During a burst the core sends no further addresses. Instead it pulses an increment strobe each time a data phase completes. The block keeps a word pointer, loaded at the start of the transaction and advanced by one DWORD on each increment. On a user write phase the pointer selects a word of an internal register file, and the active-low byte enables pick which bytes are written. On a configuration write phase it selects the command register or one of the two base registers. For reads the block returns the word or configuration register at the current pointer.

Write data has no back-pressure. The increment strobe is the valid signal and the block is always ready, so the data is taken in the cycle it appears. Read data follows the pointer combinationally, and the core samples it when it completes a phase.

Top module: `pci_tgt_decoder`

## Requirements
- R1: After reset, all register file words, both base registers and both enable bits are zero. Configuration offset 5 then reads 32'h0000_0001, and no address selects.
- R2: `rd_decode` is high exactly when `addr_valid` is high and `cbe_n` holds a read command: 0010, 0110, 1100 or 1110. It is low otherwise, including whenever `addr_valid` is low.
- R3: `wr_decode` is high exactly when `addr_valid` is high and `cbe_n` holds a write command: 0011, 0111 or 1111.
- R4: `select` is high exactly when `addr_valid` is high and one of two conditions holds. Memory match: a memory command (0110, 0111, 1100, 1110 or 1111), command register bit 1 set, and `ad_in[31:12]` equal to the memory base bits 31:12. I/O match: an I/O command (0010 or 0011), command register bit 0 set, and `ad_in[31:8]` equal to the I/O base bits 31:8.
- R5: A cycle with `addr_valid` high loads the word pointer from `ad_in`. A cycle with `addr_inc` high and `addr_valid` low advances the pointer by one DWORD (byte address +4). When both are high in the same cycle, the load wins and there is no advance.
- R6: `usr_wr_stb` equals `usr_write` AND `addr_inc`. On such a cycle, register file word `addr[5:2]` takes byte b of `ad_in` (bits 8b+7:8b) for each b where `cbe_n[b]` is 0. Other bytes keep their value, and the write never waits on any other condition.
- R7: `cfg_wr_stb` equals `cfg_write` AND `addr_inc`. On such a cycle, pointer offset `addr[7:2]` selects the target: 1 is the command register (bit 1 memory enable, bit 0 I/O enable), 4 is memory base bits 31:12, and 5 is I/O base bits 31:8. Each byte is masked by its byte enable, and writes to any other offset change nothing.
- R8: `usr_rd_data` is the register file word at pointer `addr[5:2]` while `usr_read` is high, and zero while it is low.
- R9: While `cfg_read` is high, `cfg_rd_data` depends on the offset. Offset 1 reads the two enable bits in bits 1:0. Offset 4 reads the memory base with bits 11:0 zero. Offset 5 reads the I/O base with bits 7:1 zero and bit 0 one. Any other offset reads zero, and the output is zero while `cfg_read` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address phase: `ad_in` holds address, `cbe_n` holds command |
| addr_inc | input | 1 | Data phase completed; write data valid on writes |
| ad_in | input | 32 | Shared address / write data bus |
| cbe_n | input | 4 | Command in address phase, active-low byte enables after |
| usr_write | input | 1 | Core indication: user write transaction in progress |
| cfg_write | input | 1 | Core indication: configuration write in progress |
| usr_read | input | 1 | Core indication: user read transaction in progress |
| cfg_read | input | 1 | Core indication: configuration read in progress |
| rd_decode | output | 1 | Read command decode |
| wr_decode | output | 1 | Write command decode |
| select | output | 1 | Address hits an enabled base window |
| usr_wr_stb | output | 1 | Per-DWORD user write strobe |
| cfg_wr_stb | output | 1 | Per-DWORD configuration write strobe |
| usr_rd_data | output | 32 | User read data at the current pointer |
| cfg_rd_data | output | 32 | Configuration read data at the current offset |

## Verification
The collision that matters is a new address phase landing in the same cycle as an increment strobe, where the pointer load and the pointer advance compete. The bench first fills the register file with distinct words. It then raises `addr_valid` and `addr_inc` together and checks that the next read returns the word at the newly loaded address, not the word one DWORD past it. Random bursts that wrap the pointer, together with masked writes to the base registers, check that later selects and reads follow the values the bench's own model predicts.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [3:0] {
    CMD_IO_RD   = 4'b0010,
    CMD_IO_WR   = 4'b0011,
    CMD_MEM_RD  = 4'b0110,
    CMD_MEM_WR  = 4'b0111,
    CMD_CFG_RD  = 4'b1010,
    CMD_CFG_WR  = 4'b1011,
    CMD_MEM_RDM = 4'b1100,
    CMD_MEM_RDL = 4'b1110,
    CMD_MEM_WRI = 4'b1111
  } pci_cmd_e;

  // DWORD offsets in configuration space
  localparam logic [5:0] OFS_CMD     = 6'd1;
  localparam logic [5:0] OFS_BAR_MEM = 6'd4;
  localparam logic [5:0] OFS_BAR_IO  = 6'd5;

  function automatic logic cmd_is_read(input logic [3:0] c);
    return (c == CMD_IO_RD) || (c == CMD_MEM_RD) ||
           (c == CMD_MEM_RDM) || (c == CMD_MEM_RDL);
  endfunction

  function automatic logic cmd_is_write(input logic [3:0] c);
    return (c == CMD_IO_WR) || (c == CMD_MEM_WR) || (c == CMD_MEM_WRI);
  endfunction

  function automatic logic cmd_is_mem(input logic [3:0] c);
    return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) || (c == CMD_MEM_RDM) ||
           (c == CMD_MEM_RDL) || (c == CMD_MEM_WRI);
  endfunction

  function automatic logic cmd_is_io(input logic [3:0] c);
    return (c == CMD_IO_RD) || (c == CMD_IO_WR);
  endfunction

endpackage

// File: rtl/tgt_addr_tracker.sv
module tgt_addr_tracker #(
  parameter int WW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [WW-1:0] load_word,
  output logic [WW-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (load) word <= load_word;
    else if (step) word <= word + 1'b1;
  end

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (word == WW'($past(word) + 1)));
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word == $past(load_word)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(word));

endmodule

// File: rtl/tgt_cmd_decode.sv
module tgt_cmd_decode
  import pci_tgt_pkg::*;
#(
  parameter int MW = 12,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_valid,
  input  logic [31:IW]  hi_addr,
  input  logic [3:0]    cmd,
  input  logic          mem_en,
  input  logic          io_en,
  input  logic [31:MW]  bar_mem,
  input  logic [31:IW]  bar_io,
  output logic          rd_dec,
  output logic          wr_dec,
  output logic          sel
);

  logic mem_hit, io_hit;

  always_comb begin
    mem_hit = cmd_is_mem(cmd) && mem_en && (hi_addr[31:MW] == bar_mem);
    io_hit  = cmd_is_io(cmd)  && io_en  && (hi_addr == bar_io);
    rd_dec  = addr_valid && cmd_is_read(cmd);
    wr_dec  = addr_valid && cmd_is_write(cmd);
    sel     = addr_valid && (mem_hit || io_hit);
  end

  a_r2_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_dec && wr_dec));
  a_r4_sel_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> addr_valid);

endmodule

// File: rtl/tgt_cfg_regs.sv
module tgt_cfg_regs
  import pci_tgt_pkg::*;
#(
  parameter int MW = 12,
  parameter int IW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         rd_en,
  input  logic [5:0]   ofs,
  input  logic [3:0]   be_n,
  input  logic [1:0]   wd_cmd,
  input  logic [31:MW] wd_mem,
  input  logic [31:IW] wd_io,
  output logic         mem_en,
  output logic         io_en,
  output logic [31:MW] bar_mem,
  output logic [31:IW] bar_io,
  output logic [31:0]  rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en  <= 1'b0;
      io_en   <= 1'b0;
      bar_mem <= '0;
      bar_io  <= '0;
    end else if (we) begin
      case (ofs)
        OFS_CMD: if (!be_n[0]) begin
          mem_en <= wd_cmd[1];
          io_en  <= wd_cmd[0];
        end
        OFS_BAR_MEM:
          for (int i = MW; i < 32; i++)
            if (!be_n[i/8]) bar_mem[i] <= wd_mem[i];
        OFS_BAR_IO:
          for (int i = IW; i < 32; i++)
            if (!be_n[i/8]) bar_io[i] <= wd_io[i];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (ofs)
        OFS_CMD:     rdata = {30'b0, mem_en, io_en};
        OFS_BAR_MEM: rdata = {bar_mem, {MW{1'b0}}};
        OFS_BAR_IO:  rdata = {bar_io, {(IW-1){1'b0}}, 1'b1};
        default:     rdata = '0;
      endcase
    end
  end

  a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && ofs == OFS_BAR_MEM) |=> $stable(bar_mem));
  a_r7_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && ofs == OFS_BAR_IO) |=> $stable(bar_io));
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && ofs == OFS_CMD) |=> $stable({mem_en, io_en}));

endmodule

// File: rtl/tgt_user_regfile.sv
module tgt_user_regfile #(
  parameter  int DEPTH = 16,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] idx,
  input  logic [31:0]     wdata,
  input  logic [3:0]      be_n,
  output logic [31:0]     rdata
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (we) begin
      for (int b = 0; b < 4; b++)
        if (!be_n[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  assign rdata = mem[idx];

  for (genvar w = 0; w < DEPTH; w++) begin : g_chk
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && idx == IDXW'(w)) |=> $stable(mem[w]));
  end

endmodule

// File: rtl/pci_tgt_decoder.sv
module pci_tgt_decoder #(
  parameter int DEPTH = 16,
  parameter int MW    = 12,
  parameter int IW    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_valid,
  input  logic        addr_inc,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        usr_write,
  input  logic        cfg_write,
  input  logic        usr_read,
  input  logic        cfg_read,
  output logic        rd_decode,
  output logic        wr_decode,
  output logic        select,
  output logic        usr_wr_stb,
  output logic        cfg_wr_stb,
  output logic [31:0] usr_rd_data,
  output logic [31:0] cfg_rd_data
);

  localparam int IDXW = $clog2(DEPTH);
  localparam int WW   = (IDXW > 6) ? IDXW : 6;

  logic [WW-1:0] word;
  logic          mem_en, io_en;
  logic [31:MW]  bar_mem;
  logic [31:IW]  bar_io;
  logic [31:0]   rf_rdata;

  assign usr_wr_stb  = usr_write && addr_inc;
  assign cfg_wr_stb  = cfg_write && addr_inc;
  assign usr_rd_data = usr_read ? rf_rdata : '0;

  tgt_addr_tracker #(.WW(WW)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_valid),
    .step      (addr_inc),
    .load_word (ad_in[WW+1:2]),
    .word      (word)
  );

  tgt_cmd_decode #(.MW(MW), .IW(IW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .hi_addr    (ad_in[31:IW]),
    .cmd        (cbe_n),
    .mem_en     (mem_en),
    .io_en      (io_en),
    .bar_mem    (bar_mem),
    .bar_io     (bar_io),
    .rd_dec     (rd_decode),
    .wr_dec     (wr_decode),
    .sel        (select)
  );

  tgt_cfg_regs #(.MW(MW), .IW(IW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_wr_stb),
    .rd_en   (cfg_read),
    .ofs     (word[5:0]),
    .be_n    (cbe_n),
    .wd_cmd  (ad_in[1:0]),
    .wd_mem  (ad_in[31:MW]),
    .wd_io   (ad_in[31:IW]),
    .mem_en  (mem_en),
    .io_en   (io_en),
    .bar_mem (bar_mem),
    .bar_io  (bar_io),
    .rdata   (cfg_rd_data)
  );

  tgt_user_regfile #(.DEPTH(DEPTH)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (usr_wr_stb),
    .idx   (word[IDXW-1:0]),
    .wdata (ad_in),
    .be_n  (cbe_n),
    .rdata (rf_rdata)
  );

endmodule

// File: tb/tb_pci_tgt_decoder.sv
module tb_pci_tgt_decoder;
  import pci_tgt_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_valid = 0, addr_inc = 0, usr_write = 0, cfg_write = 0, usr_read = 0, cfg_read = 0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = '0;
  logic rd_decode, wr_decode, select, usr_wr_stb, cfg_wr_stb;
  logic [31:0] usr_rd_data, cfg_rd_data;

  int errors = 0, checks = 0;

  logic [31:0] m_mem [16];
  logic [1:0]  m_en;
  logic [31:0] m_bar_mem, m_bar_io, m_addr;

  pci_tgt_decoder dut (.*);

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (!be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic exp_rd(input logic [3:0] c);
    return c == 4'b0010 || c == 4'b0110 || c == 4'b1100 || c == 4'b1110;
  endfunction
  function automatic logic exp_wr(input logic [3:0] c);
    return c == 4'b0011 || c == 4'b0111 || c == 4'b1111;
  endfunction
  function automatic logic exp_sel(input logic [31:0] a, input logic [3:0] c);
    logic memc = c == 4'b0110 || c == 4'b0111 || c == 4'b1100 || c == 4'b1110 || c == 4'b1111;
    logic ioc  = c == 4'b0010 || c == 4'b0011;
    return (memc && m_en[1] && a[31:12] == m_bar_mem[31:12]) ||
           (ioc && m_en[0] && a[31:8] == m_bar_io[31:8]);
  endfunction
  function automatic logic [31:0] cfg_val(input logic [5:0] o);
    case (o)
      6'd1: return {30'b0, m_en};
      6'd4: return m_bar_mem;
      6'd5: return m_bar_io | 32'h1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic drive(input logic v, input logic inc, input logic [31:0] ad, input logic [3:0] be,
                       input logic uw, input logic cw, input logic ur, input logic cr);
    @(negedge clk);
    addr_valid = v; addr_inc = inc; ad_in = ad; cbe_n = be;
    usr_write = uw; cfg_write = cw; usr_read = ur; cfg_read = cr;
    #1;
  endtask

  task automatic start(input logic [31:0] a, input logic [3:0] c);
    drive(1, 0, a, c, 0, 0, 0, 0);
    check("R2 rd_decode", 32'(rd_decode), 32'(exp_rd(c)));
    check("R3 wr_decode", 32'(wr_decode), 32'(exp_wr(c)));
    check("R4 select", 32'(select), 32'(exp_sel(a, c)));
    m_addr = a;
  endtask

  task automatic idle();
    drive(0, 0, $urandom, 4'($urandom), 0, 0, 0, 0);
    check("R2 rd_decode gated", 32'(rd_decode), 0);
    check("R4 select gated", 32'(select), 0);
    check("R8 usr_rd_data gated", usr_rd_data, 0);
    check("R9 cfg_rd_data gated", cfg_rd_data, 0);
  endtask

  task automatic wbeat_user(input logic [31:0] d, input logic [3:0] be);
    drive(0, 1, d, be, 1, 0, 0, 0);
    check("R6 usr_wr_stb", 32'(usr_wr_stb), 1);
    check("R7 cfg_wr_stb idle", 32'(cfg_wr_stb), 0);
    m_mem[m_addr[5:2]] = merge(m_mem[m_addr[5:2]], d, be);
    m_addr += 4;
  endtask

  task automatic wbeat_cfg(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] t;
    drive(0, 1, d, be, 0, 1, 0, 0);
    check("R7 cfg_wr_stb", 32'(cfg_wr_stb), 1);
    check("R6 usr_wr_stb idle", 32'(usr_wr_stb), 0);
    case (m_addr[7:2])
      6'd1: begin t = merge({30'b0, m_en}, d, be); m_en = t[1:0]; end
      6'd4: m_bar_mem = merge(m_bar_mem, d, be) & 32'hFFFF_F000;
      6'd5: m_bar_io  = merge(m_bar_io, d, be) & 32'hFFFF_FF00;
      default: ;
    endcase
    m_addr += 4;
  endtask

  task automatic rbeat_user(input string req);
    drive(0, 1, 32'h0, 4'h0, 0, 0, 1, 0);
    check(req, usr_rd_data, m_mem[m_addr[5:2]]);
    m_addr += 4;
  endtask

  task automatic rbeat_cfg(input string req);
    drive(0, 1, 32'h0, 4'h0, 0, 0, 0, 1);
    check(req, cfg_rd_data, cfg_val(m_addr[7:2]));
    m_addr += 4;
  endtask

  task automatic cfg_wr(input logic [7:0] o, input logic [31:0] d, input logic [3:0] be);
    start({24'b0, o}, CMD_CFG_WR);
    wbeat_cfg(d, be);
    idle();
  endtask

  function automatic logic [31:0] pick_addr();
    if ($urandom_range(0, 3) == 0) return $urandom;
    if ($urandom_range(0, 1) == 0) return m_bar_mem | ($urandom & 32'hFFF);
    return m_bar_io | ($urandom & 32'hFF);
  endfunction

  initial begin
    logic [3:0] wcmd [3] = '{4'b0011, 4'b0111, 4'b1111};
    logic [3:0] rcmd [4] = '{4'b0010, 4'b0110, 4'b1100, 4'b1110};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    m_en = '0; m_bar_mem = '0; m_bar_io = '0; m_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    start(32'h0000_0010, CMD_CFG_RD);
    rbeat_cfg("R1 mem base reset");
    rbeat_cfg("R1 io base reset");
    idle();
    start(32'h0000_0004, CMD_CFG_RD);
    rbeat_cfg("R1 enables reset");
    idle();
    start(32'h0000_0000, CMD_MEM_RD);
    check("R1 no select after reset", 32'(select), 0);
    rbeat_user("R1 regfile reset");
    idle();

    // R7 configuration writes, masked bytes, ignored offset
    cfg_wr(8'h10, 32'h8000_0ABC, 4'h0);
    cfg_wr(8'h10, 32'h1234_5678, 4'b0111);
    cfg_wr(8'h14, 32'h0000_C1AB, 4'h0);
    cfg_wr(8'h04, 32'h0000_0002, 4'h0);
    cfg_wr(8'h00, 32'hFFFF_FFFF, 4'h0);
    start(32'h0000_0000, CMD_CFG_RD);
    for (int i = 0; i < 6; i++) rbeat_cfg("R9 cfg readback");
    idle();
    check("R7 masked mem base", m_bar_mem, 32'h1200_0000);

    // R4 enable qualification: memory on, I/O off
    start(m_bar_mem | 32'h40, CMD_MEM_RD);
    idle();
    start(m_bar_io | 32'h4, CMD_IO_RD);
    check("R4 io disabled", 32'(select), 0);
    idle();
    cfg_wr(8'h04, 32'h0000_0003, 4'h0);

    // fill register file with distinct words
    start(m_bar_mem, CMD_MEM_WR);
    for (int i = 0; i < 16; i++) wbeat_user(32'hA500_0000 + i * 32'h0101, 4'h0);
    idle();

    // R5 collision: load and increment in the same cycle
    drive(1, 1, m_bar_mem | 32'h18, CMD_MEM_RD, 0, 0, 0, 0);
    m_addr = m_bar_mem | 32'h18;
    rbeat_user("R5 load wins over step");
    rbeat_user("R5 step after collision");
    idle();

    // R6 partial byte write
    start(m_bar_mem | 32'h8, CMD_MEM_WR);
    wbeat_user(32'hDEAD_BEEF, 4'b1010);
    idle();
    start(m_bar_mem | 32'h8, CMD_MEM_RD);
    rbeat_user("R6 byte mask");
    idle();

    // random traffic
    for (int it = 0; it < 500; it++) begin
      int k = $urandom_range(0, 4);
      int n = $urandom_range(1, 6);
      case (k)
        0: begin
          start(pick_addr(), wcmd[$urandom_range(0, 2)]);
          for (int j = 0; j < n; j++) wbeat_user($urandom, 4'($urandom));
        end
        1: begin
          start(pick_addr(), rcmd[$urandom_range(0, 3)]);
          for (int j = 0; j < n; j++) rbeat_user("R8 burst read");
        end
        2: start(pick_addr(), 4'($urandom));
        3: cfg_wr(8'h04, $urandom, 4'($urandom));
        default: begin
          start(32'h0000_0004, CMD_CFG_RD);
          for (int j = 0; j < n; j++) rbeat_cfg("R9 random cfg read");
        end
      endcase
      idle();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule